// File: doc/BRIEF.md
# Double-Transition CRC Control and Status

This block holds the control and status logic around a 32-bit CRC accumulator for the double-transition data phases of a parallel SCSI-style link. The accumulator takes one byte per data strobe. A check strobe compares the running value with a received 32-bit CRC. A sticky error flag records a mismatch, and that flag can be mirrored into an interrupt-status bit. The accumulator can be reseeded in three ways: automatically after each check, by an external strobe from the phase-control logic, or by a test bit that forces a reseed.

In target mode, a byte-interval counter decides when the device asks for a CRC exchange. A protocol monitor flags a bus phase change that is not preceded by a CRC request. A host reads and writes four byte-wide registers through a simple bus with a read strobe. Address 0 is control 0, address 1 is control 1, address 2 is interrupt status 0 and address 3 is interrupt status 1.

Top module: `dt_crc_ctl`

## Requirements
- R1: After reset, all four registers read 0x00, `crc_val` is 0xFFFFFFFF, and `crc_req` and `irq_crc` are low.
- R2: Each data strobe updates `crc_val` with the byte, using polynomial 0x04C11DB7, most significant bit first, no reflection and no final inversion. Seed 0xFFFFFFFF followed by the ASCII bytes "123456789" gives 0x0376E6E7.
- R3: In control 1, bit 7 is the error flag. A check strobe during DT Data-In (`dt_in` high) whose `rx_crc` differs from `crc_val` sets the flag. The flag stays set until cleared. A check strobe outside DT Data-In never sets it.
- R4: While control 0 bit 7 (checking disable) is set, a mismatch does not set the error flag. Bytes are still accumulated and target-mode requests are still issued.
- R5: Writing control 1 with bit 7 set clears the error flag. Reading address 2 or address 3 also clears it. The clear is visible on the next cycle.
- R6: Interrupt status 0 bit 0 and `irq_crc` show the error flag only while checking is enabled (control 0 bit 7 clear) and `par_int_en` is high.
- R7: Control 0 bits 3:0 hold the interval N. In target mode, during DT Data-In or DT Data-Out, `crc_req` pulses high for one cycle after every 2^(N+1) data strobes, and the byte count then restarts. In initiator mode `crc_req` never rises.
- R8: Writing control 0 with bit 5 set clears the interval count to zero. A request is not raised in that cycle. Bit 5 always reads 0.
- R9: With control 1 bit 5 (auto-seed) set, a check strobe during DT Data-In reseeds `crc_val` to 0xFFFFFFFF on the next cycle. With auto-seed clear, the check leaves `crc_val` unchanged.
- R10: `reseed_stb` reseeds `crc_val` to 0xFFFFFFFF on the next cycle, whatever the transfer state.
- R11: Writing control 1 with bit 4 set raises the test-seed bit for one cycle. On the clock after that the accumulator reseeds and the bit clears. Reseeding takes priority over a data strobe in the same cycle.
- R12: If a DT data byte has moved since the last CRC request and `phase_chg` pulses while control 0 bit 6 is clear, interrupt status 1 bit 0 sets. A CRC request is either `crc_req` or `crc_req_in`. Reading address 3 clears that bit. With control 0 bit 6 set, a phase change never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| target_mode | input | 1 | High when the device acts as target |
| dt_in | input | 1 | DT Data-In phase active |
| dt_out | input | 1 | DT Data-Out phase active |
| data_stb | input | 1 | One byte transferred |
| data_byte | input | 8 | Byte transferred |
| chk_stb | input | 1 | Compare accumulator with received CRC |
| rx_crc | input | 32 | Received CRC value |
| reseed_stb | input | 1 | External reseed request |
| phase_chg | input | 1 | Bus phase change pulse |
| crc_req_in | input | 1 | CRC request seen from the other side |
| par_int_en | input | 1 | Parity/CRC interrupt enable |
| crc_req | output | 1 | Target-mode CRC request pulse |
| crc_val | output | 32 | Current accumulator value |
| irq_crc | output | 1 | Mirrored CRC error interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- a request is never two cycles wide and is only issued in target-mode DT phases;
- the error flag never rises while checking is disabled;
- a write-one or a status read clears the flag;
- a counter reset suppresses a request;
- a test-seed write reseeds within two cycles.

The bench scenarios cover what needs chosen data:
- the CRC value for a known string;
- exact request spacing for several intervals, including restart after a counter reset;
- the enable combinations of the interrupt mirror;
- the auto-seed against manual-seed choice;
- the phase-change protocol error with and without a prior request.

// File: rtl/dt_crc_ctl.sv
module dt_crc_ctl #(
  parameter int INTV_W = 4,
  parameter logic [31:0] POLY = 32'h04C11DB7,
  parameter logic [31:0] SEED = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        target_mode,
  input  logic        dt_in,
  input  logic        dt_out,
  input  logic        data_stb,
  input  logic [7:0]  data_byte,
  input  logic        chk_stb,
  input  logic [31:0] rx_crc,
  input  logic        reseed_stb,
  input  logic        phase_chg,
  input  logic        crc_req_in,
  input  logic        par_int_en,
  output logic        crc_req,
  output logic [31:0] crc_val,
  output logic        irq_crc
);
  localparam int CNT_W = (1 << INTV_W) + 1;

  logic              dis_chk, dis_proto, auto_seed, tst_seed, err, proto_err, pending;
  logic [INTV_W-1:0] intv;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  wire wr0     = wr_en && addr == 2'd0;
  wire wr1     = wr_en && addr == 2'd1;
  wire rd_is   = rd_en && addr[1];
  wire dt      = dt_in || dt_out;
  wire cnt_en  = data_stb && target_mode && dt;
  wire cnt_rst = wr0 && wdata[5];
  wire [CNT_W-1:0] limit = {{(CNT_W-2){1'b0}}, 2'd2} << intv;
  wire hit     = cnt_en && (cnt + 1'b1 == limit);
  wire chk     = chk_stb && dt_in;
  wire mismatch = chk && (crc_val != rx_crc);
  wire set_err = mismatch && !dis_chk;
  wire reseed  = tst_seed || reseed_stb || (chk && auto_seed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_chk <= 1'b0; dis_proto <= 1'b0; intv <= '0;
      auto_seed <= 1'b0; tst_seed <= 1'b0;
    end else begin
      if (wr0) begin
        dis_chk   <= wdata[7];
        dis_proto <= wdata[6];
        intv      <= wdata[INTV_W-1:0];
      end
      if (wr1) auto_seed <= wdata[5];
      tst_seed <= wr1 && wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; crc_req <= 1'b0;
    end else begin
      crc_req <= hit && !cnt_rst;
      if (cnt_rst || hit) cnt <= '0;
      else if (cnt_en)    cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_val <= SEED;
    else if (reseed)   crc_val <= SEED;
    else if (data_stb) crc_val <= crc_step(crc_val, data_byte);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if (set_err) err <= 1'b1;
    else if ((wr1 && wdata[7]) || rd_is) err <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0; proto_err <= 1'b0;
    end else begin
      if (phase_chg || crc_req || crc_req_in) pending <= 1'b0;
      else if (data_stb && dt) pending <= 1'b1;
      if (phase_chg && pending && !crc_req && !crc_req_in && !dis_proto) proto_err <= 1'b1;
      else if (rd_en && addr == 2'd3) proto_err <= 1'b0;
    end
  end

  assign irq_crc = err && !dis_chk && par_int_en;

  always_comb begin
    case (addr)
      2'd0:    rdata = {dis_chk, dis_proto, 2'b00, {(4-INTV_W){1'b0}}, intv};
      2'd1:    rdata = {err, 1'b0, auto_seed, tst_seed, 4'b0000};
      2'd2:    rdata = {7'd0, irq_crc};
      default: rdata = {7'd0, proto_err};
    endcase
  end

  a_r7_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    crc_req |=> !crc_req);
  a_r7_req_target_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_req) |-> $past(target_mode && (dt_in || dt_out) && data_stb));
  a_r4_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_chk && !wr0) |=> !$rose(err));
  a_r5_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && wdata[7] && !chk_stb) |=> !err);
  a_r5_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1] && !chk_stb) |=> !err);
  a_r8_reset_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[5]) |=> !crc_req);
  a_r11_test_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && wdata[4]) |=> ##1 (crc_val == SEED));
endmodule

// File: tb/tb_dt_crc_ctl.sv
module tb_dt_crc_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, target_mode = 0, dt_in = 0, dt_out = 0, data_stb = 0;
  logic chk_stb = 0, reseed_stb = 0, phase_chg = 0, crc_req_in = 0, par_int_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, data_byte = 0, rdata;
  logic [31:0] rx_crc = 0, crc_val;
  logic crc_req, irq_crc;
  int tests = 0, fails = 0;

  dt_crc_ctl dut (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 7; i >= 0; i--) r = (r[31] ^ d[i]) ? ({r[30:0],1'b0} ^ 32'h04C11DB7) : {r[30:0],1'b0};
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1; #1 d = rdata; @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic send(input logic [7:0] b);
    data_byte = b; data_stb = 1; @(negedge clk); data_stb = 0;
  endtask

  task automatic check_crc(input logic [31:0] v);
    rx_crc = v; chk_stb = 1; @(negedge clk); chk_stb = 0;
  endtask

  task automatic reseed();
    reseed_stb = 1; @(negedge clk); reseed_stb = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin peek(a[1:0], d); chk("R1 reg", {24'd0, d}, 0); end
    chk("R1 crc", crc_val, 32'hFFFFFFFF);
    chk("R1 req", {31'd0, crc_req}, 0);
    chk("R1 irq", {31'd0, irq_crc}, 0);
  endtask

  task automatic t_crc_known();
    string s = "123456789";
    logic [31:0] m = 32'hFFFFFFFF;
    reseed();
    for (int i = 0; i < 9; i++) begin send(s[i]); m = ref_crc(m, s[i]); end
    chk("R2 known string", crc_val, 32'h0376E6E7);
    chk("R2 model", crc_val, m);
    reseed();
    m = 32'hFFFFFFFF;
    for (int i = 0; i < 5; i++) begin send(8'hA5 ^ i[7:0]); m = ref_crc(m, 8'hA5 ^ i[7:0]); end
    chk("R2 pattern", crc_val, m);
  endtask

  task automatic t_error_flow();
    logic [7:0] d;
    logic [31:0] v;
    wreg(1, 8'h00);
    dt_in = 1; reseed(); send(8'h11); v = crc_val;
    check_crc(v); peek(1, d);
    chk("R3 match no err", {31'd0, d[7]}, 0);
    chk("R9 manual keeps", crc_val, v);
    dt_in = 0; check_crc(~v); peek(1, d);
    chk("R3 outside DT-in", {31'd0, d[7]}, 0);
    dt_in = 1; check_crc(~v); peek(1, d);
    chk("R3 mismatch sets", {31'd0, d[7]}, 1);
    send(8'h22); peek(1, d);
    chk("R3 sticky", {31'd0, d[7]}, 1);
    par_int_en = 0; peek(2, d);
    chk("R6 mirror off enable", {24'd0, d}, 0);
    par_int_en = 1; peek(2, d);
    chk("R6 mirror on", {24'd0, d}, 1);
    chk("R6 irq on", {31'd0, irq_crc}, 1);
    wreg(0, 8'h80); peek(2, d);
    chk("R6 mirror off chk-dis", {24'd0, d}, 0);
    wreg(0, 8'h00);
    wreg(1, 8'h80); peek(1, d);
    chk("R5 write one clears", {31'd0, d[7]}, 0);
    check_crc(~crc_val); rreg(2, d); peek(1, d);
    chk("R5 read IS0 clears", {31'd0, d[7]}, 0);
    check_crc(~crc_val); rreg(3, d); peek(1, d);
    chk("R5 read IS1 clears", {31'd0, d[7]}, 0);
    wreg(0, 8'h80);
    v = crc_val; send(8'h33);
    check_crc(~crc_val); peek(1, d);
    chk("R4 disabled no err", {31'd0, d[7]}, 0);
    chk("R4 still computes", crc_val, ref_crc(v, 8'h33));
    wreg(0, 8'h00); dt_in = 0; par_int_en = 0;
  endtask

  task automatic t_seed();
    logic [7:0] d;
    dt_in = 1; wreg(1, 8'h20); send(8'h44);
    check_crc(crc_val);
    chk("R9 auto-seed", crc_val, 32'hFFFFFFFF);
    send(8'h55); dt_in = 0; reseed();
    chk("R10 ext reseed", crc_val, 32'hFFFFFFFF);
    send(8'h66); wreg(1, 8'h10); peek(1, d);
    chk("R11 bit set", {31'd0, d[4]}, 1);
    data_byte = 8'h77; data_stb = 1; @(negedge clk); data_stb = 0;
    chk("R11 reseed wins", crc_val, 32'hFFFFFFFF);
    peek(1, d);
    chk("R11 bit clears", {31'd0, d[4]}, 0);
    wreg(1, 8'h00);
  endtask

  task automatic t_interval();
    int n;
    logic [7:0] d;
    target_mode = 1; dt_out = 1;
    wreg(0, 8'h20);
    send(8'h01); chk("R7 N0 first", {31'd0, crc_req}, 0);
    send(8'h02); chk("R7 N0 second", {31'd0, crc_req}, 1);
    send(8'h03); chk("R7 pulse one cycle", {31'd0, crc_req}, 0);
    wreg(0, 8'h22); n = 0;
    for (int i = 1; i <= 16; i++) begin
      send(i[7:0]); if (crc_req) n++;
      if (i == 8) chk("R7 N2 at 8", {31'd0, crc_req}, 1);
    end
    chk("R7 N2 count", n, 2);
    wreg(0, 8'h20); send(8'h01); wreg(0, 8'h20);
    send(8'h02); chk("R8 restart", {31'd0, crc_req}, 0);
    send(8'h03); chk("R8 after restart", {31'd0, crc_req}, 1);
    peek(0, d); chk("R8 reads zero", {31'd0, d[5]}, 0);
    wreg(0, 8'h20); send(8'h01);
    addr = 0; wdata = 8'h20; wr_en = 1; data_stb = 1; @(negedge clk); wr_en = 0; data_stb = 0;
    chk("R8 reset blocks req", {31'd0, crc_req}, 0);
    target_mode = 0; wreg(0, 8'h20); n = 0;
    for (int i = 0; i < 6; i++) begin send(8'h10); if (crc_req) n++; end
    chk("R7 initiator none", n, 0);
    dt_out = 0;
  endtask

  task automatic t_proto();
    logic [7:0] d;
    dt_out = 1; target_mode = 1; wreg(0, 8'h23);
    send(8'h01); send(8'h02);
    phase_chg = 1; @(negedge clk); phase_chg = 0; peek(3, d);
    chk("R12 missing req", {24'd0, d}, 1);
    rreg(3, d); peek(3, d);
    chk("R12 read clears", {24'd0, d}, 0);
    wreg(0, 8'h20); send(8'h01); send(8'h02); @(negedge clk);
    phase_chg = 1; @(negedge clk); phase_chg = 0; peek(3, d);
    chk("R12 req given", {24'd0, d}, 0);
    target_mode = 0; send(8'h05); crc_req_in = 1; @(negedge clk); crc_req_in = 0;
    phase_chg = 1; @(negedge clk); phase_chg = 0; peek(3, d);
    chk("R12 req in", {24'd0, d}, 0);
    wreg(0, 8'h43); send(8'h07);
    phase_chg = 1; @(negedge clk); phase_chg = 0; peek(3, d);
    chk("R12 disabled", {24'd0, d}, 0);
    dt_out = 0; wreg(0, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        t_reset(); t_crc_known(); t_error_flow(); t_seed(); t_interval(); t_proto();
      end
      begin
        repeat (20000) @(negedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule